// File: doc/BRIEF.md
# Commit Trace Event Matcher

This block watches the stream of retired-instruction records a processor core produces and compares each record against a pattern that software programs. A record has five fields: the instruction word, the PC it retired from, the PC that follows it, the memory address it touched and its data value. Each field has a value and a bit mask. A record matches only when every field agrees with its value on all mask bits.

Each matching record advances an event counter. When the counter reaches the programmed threshold, the block pushes a match packet into a four-entry queue. The packet holds the unit's identifier plus the record's address and data. A downstream action engine drains the queue.

Configuration arrives through a plain register-write port. A separate clear command resets the counter. Both carry a unit index, and the block acts on them only when that index equals its own `UNIT_ID` parameter.

Records enter on a valid/ready handshake and packets leave on one. Back-pressure works as follows:
- A record is taken only on a cycle where `rec_valid` and `rec_ready` are both high.
- While the queue is full, `rec_ready` is low and `stall` is high, so no packet is ever dropped.
- A packet stays on `pkt_*`, unchanged, until the cycle in which `pkt_ready` is high.

Top module: `trace_event_matcher`

## Requirements
- R1: An accepted record matches only when all five fields satisfy `(field & mask) == (value & mask)` in the same cycle. A single masked bit that differs in any one field prevents the match.
- R2: Bits whose mask bit is 0 are ignored. For example, an instruction mask of 0xFFFF with a value of 0x8067, and all other masks zero, matches every record whose low instruction bits are 0x8067.
- R3: The counter advances by one for each accepted matching record. Records that do not match leave the counter unchanged, and so do records offered while `rec_ready` is low.
- R4: The counter compares `counter+1` (modulo 2^CNT_W) with the threshold. On equality it emits one packet and returns to zero. A threshold of 0 or 1 emits a packet for every matching record.
- R5: A packet carries `pkt_unit` = `UNIT_ID`, plus the `rec_addr` and `rec_data` of the record that fired it.
- R6: The queue holds up to `QDEPTH` packets, in order. The head packet stays valid and stable until `pkt_ready` is high.
- R7: While the queue is full, `stall` is 1 and `rec_ready` is 0. Records offered in that state are not taken and are not counted.
- R8: `cmd_clr` with `cmd_unit` = `UNIT_ID` zeroes the counter. It has priority over a match in the same cycle: that record neither counts nor fires. A clear aimed at any other index has no effect.
- R9: A write with `cfg_we` = 1 and `cfg_unit` = `UNIT_ID` loads the register selected by `cfg_sel` from `cfg_wdata`:
  - values: 0 instruction, 1 source PC, 2 next PC, 3 address, 4 data;
  - masks: 5 to 9, in the same field order;
  - threshold: 10.

  Writes aimed at another unit index have no effect. A record accepted in the same cycle as a write still uses the old settings.
- R10: After reset the counter is 0 and the queue is empty, so `pkt_valid` = 0, `stall` = 0 and `rec_ready` = 1. All masks, values and the threshold are 0, so every record matches and fires.
- R11: A packet fired by a record accepted at clock edge k is valid on `pkt_*` right after edge k if the queue was empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rec_valid | input | 1 | Record present |
| rec_ready | output | 1 | Block can take a record |
| rec_inst | input | IW | Instruction word |
| rec_pc_src | input | XW | PC the instruction retired from |
| rec_pc_dst | input | XW | Next PC |
| rec_addr | input | XW | Memory address |
| rec_data | input | XW | Data value |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_unit | input | UW | Target unit index of the write |
| cfg_sel | input | 4 | Register select (see R9) |
| cfg_wdata | input | XW | Write data |
| cmd_clr | input | 1 | Counter clear command |
| cmd_unit | input | UW | Target unit index of the clear |
| pkt_valid | output | 1 | Packet at queue head |
| pkt_ready | input | 1 | Consumer takes the head packet |
| pkt_unit | output | UW | Unit identifier |
| pkt_addr | output | XW | Address of the firing record |
| pkt_data | output | XW | Data of the firing record |
| stall | output | 1 | Queue full, input held off |

## Verification
The bench builds the block with the following parameters:
- `UNIT_ID` = 2, so clears and writes aimed at indices 0, 1 and 3 exercise the ignore path.
- `CNT_W` = 8, so counter arithmetic wraps at 256.
- `QDEPTH` = 4, so a short burst with `pkt_ready` held low fills the queue, raises `stall` and blocks records.

With thresholds of 0 to 5 and the consumer back-pressuring at random, a few thousand cycles cover the fire-and-wrap cases, and the clear and write collisions occur many times.

// File: rtl/tem_pkg.sv
package tem_pkg;
  typedef enum logic [3:0] {
    SEL_VAL_INST = 4'd0,
    SEL_VAL_PCS  = 4'd1,
    SEL_VAL_PCD  = 4'd2,
    SEL_VAL_ADDR = 4'd3,
    SEL_VAL_DATA = 4'd4,
    SEL_MSK_INST = 4'd5,
    SEL_MSK_PCS  = 4'd6,
    SEL_MSK_PCD  = 4'd7,
    SEL_MSK_ADDR = 4'd8,
    SEL_MSK_DATA = 4'd9,
    SEL_THRESH   = 4'd10
  } cfg_sel_e;

  localparam int NUM_WIDE = 4;  // source PC, next PC, address, data
endpackage

// File: rtl/tem_field_cmp.sv
module tem_field_cmp #(
  parameter int W = 64
) (
  input  logic [W-1:0] field,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] pattern,
  output logic         hit
);
  assign hit = ((field ^ pattern) & mask) == '0;
endmodule

// File: rtl/tem_event_ctr.sv
module tem_event_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             hit,
  input  logic [CNT_W-1:0] thresh,
  output logic             fire
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] nxt;
  logic             small_thr;

  assign nxt       = cnt + 1'b1;
  assign small_thr = (thresh <= CNT_W'(1));
  assign fire      = hit && !clr && (small_thr || (nxt == thresh));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (fire)   cnt <= '0;
    else if (hit)    cnt <= nxt;
  end

  AST_CLR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0)); // R8
  AST_FIRE_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (cnt == '0)); // R4
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && !clr) |=> $stable(cnt)); // R3
endmodule

// File: rtl/tem_match_fifo.sv
module tem_match_fifo #(
  parameter int W     = 130,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         full,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] fill;
  logic          push, pop;

  assign full      = (fill == CW'(DEPTH));
  assign out_valid = (fill != '0);
  assign out_data  = mem[rd_ptr];
  assign push      = in_valid;
  assign pop       = out_valid && out_ready;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> !full); // R7
  AST_HEAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R6
endmodule

// File: rtl/trace_event_matcher.sv
module trace_event_matcher
  import tem_pkg::*;
#(
  parameter int IW      = 32,
  parameter int XW      = 64,
  parameter int UW      = 2,
  parameter int UNIT_ID = 0,
  parameter int CNT_W   = 16,
  parameter int QDEPTH  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rec_valid,
  output logic          rec_ready,
  input  logic [IW-1:0] rec_inst,
  input  logic [XW-1:0] rec_pc_src,
  input  logic [XW-1:0] rec_pc_dst,
  input  logic [XW-1:0] rec_addr,
  input  logic [XW-1:0] rec_data,
  input  logic          cfg_we,
  input  logic [UW-1:0] cfg_unit,
  input  logic [3:0]    cfg_sel,
  input  logic [XW-1:0] cfg_wdata,
  input  logic          cmd_clr,
  input  logic [UW-1:0] cmd_unit,
  output logic          pkt_valid,
  input  logic          pkt_ready,
  output logic [UW-1:0] pkt_unit,
  output logic [XW-1:0] pkt_addr,
  output logic [XW-1:0] pkt_data,
  output logic          stall
);
  localparam int PKT_W = UW + 2 * XW;
  localparam logic [UW-1:0] MY_ID = UW'(UNIT_ID);

  logic [IW-1:0]    val_inst, msk_inst;
  logic [XW-1:0]    val_wide [NUM_WIDE];
  logic [XW-1:0]    msk_wide [NUM_WIDE];
  logic [XW-1:0]    rec_wide [NUM_WIDE];
  logic [CNT_W-1:0] thresh;
  logic [NUM_WIDE:0] field_hit;
  logic             cfg_mine, clr_mine, accept, hit, fire, q_full;
  logic [PKT_W-1:0] q_in, q_out;

  assign rec_wide[0] = rec_pc_src;
  assign rec_wide[1] = rec_pc_dst;
  assign rec_wide[2] = rec_addr;
  assign rec_wide[3] = rec_data;

  assign cfg_mine = cfg_we && (cfg_unit == MY_ID);
  assign clr_mine = cmd_clr && (cmd_unit == MY_ID);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_inst <= '0;
      msk_inst <= '0;
      thresh   <= '0;
      for (int i = 0; i < NUM_WIDE; i++) begin
        val_wide[i] <= '0;
        msk_wide[i] <= '0;
      end
    end else if (cfg_mine) begin
      case (cfg_sel_e'(cfg_sel))
        SEL_VAL_INST: val_inst    <= cfg_wdata[IW-1:0];
        SEL_VAL_PCS:  val_wide[0] <= cfg_wdata;
        SEL_VAL_PCD:  val_wide[1] <= cfg_wdata;
        SEL_VAL_ADDR: val_wide[2] <= cfg_wdata;
        SEL_VAL_DATA: val_wide[3] <= cfg_wdata;
        SEL_MSK_INST: msk_inst    <= cfg_wdata[IW-1:0];
        SEL_MSK_PCS:  msk_wide[0] <= cfg_wdata;
        SEL_MSK_PCD:  msk_wide[1] <= cfg_wdata;
        SEL_MSK_ADDR: msk_wide[2] <= cfg_wdata;
        SEL_MSK_DATA: msk_wide[3] <= cfg_wdata;
        SEL_THRESH:   thresh      <= cfg_wdata[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  tem_field_cmp #(.W(IW)) u_cmp_inst (
    .field(rec_inst), .mask(msk_inst), .pattern(val_inst), .hit(field_hit[0])
  );

  for (genvar g = 0; g < NUM_WIDE; g++) begin : g_wide
    tem_field_cmp #(.W(XW)) u_cmp (
      .field(rec_wide[g]), .mask(msk_wide[g]), .pattern(val_wide[g]),
      .hit(field_hit[g+1])
    );
  end

  assign rec_ready = !q_full;
  assign stall     = q_full;
  assign accept    = rec_valid && rec_ready;
  assign hit       = accept && (&field_hit);

  tem_event_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .clr(clr_mine), .hit(hit), .thresh(thresh),
    .fire(fire)
  );

  assign q_in = {MY_ID, rec_addr, rec_data};

  tem_match_fifo #(.W(PKT_W), .DEPTH(QDEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .in_valid(fire), .in_data(q_in), .full(q_full),
    .out_valid(pkt_valid), .out_ready(pkt_ready), .out_data(q_out)
  );

  assign pkt_unit = q_out[PKT_W-1 -: UW];
  assign pkt_addr = q_out[2*XW-1 -: XW];
  assign pkt_data = q_out[XW-1:0];

  AST_FIRE_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (rec_valid && rec_ready)); // R3
  AST_PKT_AFTER_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> pkt_valid); // R11
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !pkt_ready) |=> stall); // R7
  AST_PKT_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> (pkt_unit == MY_ID)); // R5
endmodule

// File: tb/tb_trace_event_matcher.sv
`timescale 1ns/1ps
module tb_trace_event_matcher;
  localparam int IW = 32, XW = 64, UW = 2, UID = 2, CW = 8, QD = 4;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          rec_valid = 0, rec_ready;
  logic [IW-1:0] rec_inst = '0;
  logic [XW-1:0] rec_pc_src = '0, rec_pc_dst = '0, rec_addr = '0, rec_data = '0;
  logic          cfg_we = 0;
  logic [UW-1:0] cfg_unit = '0, cmd_unit = '0;
  logic [3:0]    cfg_sel = '0;
  logic [XW-1:0] cfg_wdata = '0;
  logic          cmd_clr = 0, pkt_valid, pkt_ready = 1, stall;
  logic [UW-1:0] pkt_unit;
  logic [XW-1:0] pkt_addr, pkt_data;

  always #2 clk = ~clk;

  trace_event_matcher #(.IW(IW), .XW(XW), .UW(UW), .UNIT_ID(UID), .CNT_W(CW), .QDEPTH(QD)) dut (
    .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_ready(rec_ready),
    .rec_inst(rec_inst), .rec_pc_src(rec_pc_src), .rec_pc_dst(rec_pc_dst),
    .rec_addr(rec_addr), .rec_data(rec_data), .cfg_we(cfg_we), .cfg_unit(cfg_unit),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cmd_clr(cmd_clr), .cmd_unit(cmd_unit),
    .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_unit(pkt_unit),
    .pkt_addr(pkt_addr), .pkt_data(pkt_data), .stall(stall)
  );

  typedef struct packed { logic [XW-1:0] a; logic [XW-1:0] d; } pkt_t;
  logic [IW-1:0] m_vi = '0, m_mi = '0;
  logic [XW-1:0] m_vx [4];
  logic [XW-1:0] m_mx [4];
  int   m_thr = 0, m_cnt = 0;
  pkt_t m_q[$];
  int   n_run = 0, n_fail = 0, n_taken = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [XW-1:0] act, input logic [XW-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit f_match();
    logic [XW-1:0] f [4];
    bit ok;
    f[0] = rec_pc_src; f[1] = rec_pc_dst; f[2] = rec_addr; f[3] = rec_data;
    ok = ((rec_inst ^ m_vi) & m_mi) == '0;
    for (int i = 0; i < 4; i++) ok &= (((f[i] ^ m_vx[i]) & m_mx[i]) == '0);
    return ok;
  endfunction

  // One clock: compare outputs with the model before the edge, update after.
  task automatic cycle();
    bit full, acc, pop, hit, clr;
    int nxt;
    full = (m_q.size() == QD);
    chk(rec_ready == !full, "R7", "rec_ready", XW'(rec_ready), XW'(!full));
    chk(stall == full, "R7", "stall", XW'(stall), XW'(full));
    if (m_q.size() > 0) begin
      chk(pkt_valid == 1'b1, "R6", "pkt_valid", XW'(pkt_valid), 1);
      chk(pkt_unit == UW'(UID), "R5", "pkt_unit", XW'(pkt_unit), UID);
      chk(pkt_addr == m_q[0].a, "R5", "pkt_addr", pkt_addr, m_q[0].a);
      chk(pkt_data == m_q[0].d, "R5", "pkt_data", pkt_data, m_q[0].d);
    end else begin
      chk(pkt_valid == 1'b0, "R6", "pkt_valid idle", XW'(pkt_valid), 0);
    end
    acc = rec_valid && !full;
    pop = pkt_ready && (m_q.size() > 0);
    hit = acc && f_match();
    clr = cmd_clr && (cmd_unit == UW'(UID));
    if (pkt_valid && pkt_ready) n_taken++;
    @(posedge clk);
    if (pop) void'(m_q.pop_front());
    if (clr) m_cnt = 0;
    else if (hit) begin
      nxt = (m_cnt + 1) % (1 << CW);
      if (m_thr <= 1 || nxt == m_thr) begin
        m_q.push_back('{a: rec_addr, d: rec_data});
        m_cnt = 0;
      end else m_cnt = nxt;
    end
    if (cfg_we && cfg_unit == UW'(UID)) begin
      case (cfg_sel)
        4'd0: m_vi = cfg_wdata[IW-1:0];
        4'd1, 4'd2, 4'd3, 4'd4: m_vx[cfg_sel - 4'd1] = cfg_wdata;
        4'd5: m_mi = cfg_wdata[IW-1:0];
        4'd6, 4'd7, 4'd8, 4'd9: m_mx[cfg_sel - 4'd6] = cfg_wdata;
        4'd10: m_thr = int'(cfg_wdata[CW-1:0]);
        default: ;
      endcase
    end
    @(negedge clk);
  endtask

  task automatic wr(input int sel, input logic [XW-1:0] d, input int unit);
    cfg_we = 1; cfg_sel = 4'(sel); cfg_wdata = d; cfg_unit = UW'(unit);
    cycle();
    cfg_we = 0;
  endtask

  task automatic send(input logic [IW-1:0] i, input logic [XW-1:0] s, input logic [XW-1:0] t,
                      input logic [XW-1:0] a, input logic [XW-1:0] d);
    rec_valid = 1; rec_inst = i; rec_pc_src = s; rec_pc_dst = t; rec_addr = a; rec_data = d;
    cycle();
    rec_valid = 0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cycle();
  endtask

  task automatic clear_masks();
    for (int s = 5; s <= 9; s++) wr(s, '0, UID);
  endtask

  task automatic drain();
    pkt_ready = 1; idle(QD + 2);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int base;
    for (int i = 0; i < 4; i++) begin m_vx[i] = '0; m_mx[i] = '0; end
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10: reset state
    chk(pkt_valid == 0, "R10", "pkt_valid after reset", XW'(pkt_valid), 0);
    chk(stall == 0, "R10", "stall after reset", XW'(stall), 0);
    chk(rec_ready == 1, "R10", "rec_ready after reset", XW'(rec_ready), 1);
    // R10/R11: default config fires on any record, packet valid right after the edge
    send(32'h1234, 64'h1, 64'h2, 64'hA0, 64'hD0);
    chk(pkt_valid == 1, "R11", "pkt next cycle", XW'(pkt_valid), 1);
    chk(pkt_addr == 64'hA0, "R10", "default fire addr", pkt_addr, 64'hA0);
    drain();

    // R2: return detector, threshold 1
    wr(5, 64'hFFFF, UID); wr(0, 64'h8067, UID); wr(10, 1, UID);
    base = n_taken;
    send(32'hABCD8067, 64'h5, 64'h6, 64'h11, 64'h21);
    send(32'h00008066, 64'h5, 64'h6, 64'h12, 64'h22);
    send(32'h77778067, 64'h9, 64'h9, 64'h13, 64'h23);
    drain();
    chk(n_taken - base == 2, "R2", "return packets", XW'(n_taken - base), 2);

    // R1: all five fields constrained, one differing masked bit in any field blocks
    for (int s = 6; s <= 9; s++) wr(s, 64'hFF00, UID);
    for (int s = 1; s <= 4; s++) wr(s, 64'h3400, UID);
    base = n_taken;
    send(32'h8067, 64'h3400, 64'h3401, 64'h34AA, 64'h3455);
    send(32'h8167, 64'h3400, 64'h3400, 64'h3400, 64'h3400);
    send(32'h8067, 64'h3500, 64'h3400, 64'h3400, 64'h3400);
    send(32'h8067, 64'h3400, 64'h3600, 64'h3400, 64'h3400);
    send(32'h8067, 64'h3400, 64'h3400, 64'h3C00, 64'h3400);
    send(32'h8067, 64'h3400, 64'h3400, 64'h3400, 64'h2400);
    drain();
    chk(n_taken - base == 1, "R1", "joint match count", XW'(n_taken - base), 1);

    // R3/R4: threshold 3 over seven matches and interleaved misses
    clear_masks(); wr(5, 64'hFF, UID); wr(0, 64'h13, UID); wr(10, 3, UID);
    base = n_taken;
    for (int k = 0; k < 7; k++) begin
      send(32'h13, 0, 0, 64'(k), 64'(k));
      send(32'h14, 0, 0, 0, 0);
    end
    drain();
    chk(n_taken - base == 2, "R4", "threshold 3 packets", XW'(n_taken - base), 2);
    // R3: one pending count remains; two more matches reach the threshold
    base = n_taken;
    send(32'h13, 0, 0, 64'h70, 0); send(32'h13, 0, 0, 64'h71, 0);
    drain();
    chk(n_taken - base == 1, "R3", "carried count", XW'(n_taken - base), 1);

    // R8: clear for another unit ignored; own clear wins over a same-cycle match
    wr(10, 2, UID);
    base = n_taken;
    send(32'h13, 0, 0, 1, 1);
    cmd_clr = 1; cmd_unit = UW'(UID + 1); cycle(); cmd_clr = 0;
    send(32'h13, 0, 0, 2, 2);
    drain();
    chk(n_taken - base == 1, "R8", "foreign clear ignored", XW'(n_taken - base), 1);
    base = n_taken;
    send(32'h13, 0, 0, 3, 3);
    cmd_clr = 1; cmd_unit = UW'(UID); send(32'h13, 0, 0, 4, 4); cmd_clr = 0;
    send(32'h13, 0, 0, 5, 5);
    drain();
    chk(n_taken - base == 0, "R8", "own clear priority", XW'(n_taken - base), 0);

    // R9: write to another unit leaves threshold unchanged
    wr(10, 1, UID - 1);
    base = n_taken;
    send(32'h13, 0, 0, 6, 6);
    drain();
    chk(n_taken - base == 1, "R9", "foreign write ignored", XW'(n_taken - base), 1);

    // R7: consumer stalled, queue fills, further records refused and uncounted
    wr(10, 0, UID);
    pkt_ready = 0;
    for (int k = 0; k < 6; k++) send(32'h13, 0, 0, 64'(100 + k), 64'(k));
    chk(stall == 1, "R7", "stall when full", XW'(stall), 1);
    chk(rec_ready == 0, "R7", "ready low when full", XW'(rec_ready), 0);
    chk(pkt_addr == 64'd100, "R6", "head held", pkt_addr, 64'd100);
    drain();

    // Random mix: R1 R3 R4 R5 R6 against the model
    for (int k = 0; k < 3000; k++) begin
      if (k % 500 == 0) begin
        wr(5, 64'($urandom) & 64'hFFF, UID); wr(0, 64'($urandom), UID);
        wr(6 + ($urandom % 4), {$urandom, $urandom} & 64'hF0F, UID);
        wr(10, 64'($urandom % 6), UID);
      end
      rec_valid = ($urandom % 4) != 0;
      rec_inst  = m_vi ^ (($urandom % 3 == 0) ? 32'($urandom) : '0);
      rec_pc_src = m_vx[0] ^ (($urandom % 5 == 0) ? 64'($urandom) : '0);
      rec_pc_dst = m_vx[1] ^ (($urandom % 5 == 0) ? 64'($urandom) : '0);
      rec_addr  = {$urandom, $urandom};
      rec_data  = {$urandom, $urandom};
      pkt_ready = ($urandom % 10) < 6;
      cmd_clr   = ($urandom % 40) == 0;
      cmd_unit  = UW'($urandom);
      cycle();
    end
    rec_valid = 0; cmd_clr = 0;
    drain();
    summary();
  end
endmodule